// File: doc/BRIEF.md
# Escape-Byte Run-Length Expander

This block turns a compressed configuration image back into its original byte stream, for example on the path from a small boot memory to a device configuration port. Only two byte values carry meaning: all-zeros and all-ones. Either one acts as an escape, and the byte that follows it is a repeat count. The expander writes the escaped value that many times. Every other byte is a literal and goes straight through. Runs always cover whole bytes, and no run ever spans part of a byte.

Bytes enter through a valid/ready handshake and leave through a second one. A one-cycle start pulse begins a new image. It returns the decoder to its idle state and clears the error flags and the output byte counter. An end-of-image pulse marks the end of the stream. Two sticky flags report bad input: an escape with a count of zero, and an image that ends between an escape and its count. The running count of delivered bytes can be compared with the expected uncompressed length.

Top module: `rle_byte_expander`

## Requirements
- R1: An input byte that is neither 0x00 nor 0xFF, accepted outside a pending escape, comes out unchanged as exactly one output byte, in input order.
- R2: An escape byte (0x00 or 0xFF) followed by a count byte N in the range 1 to 255 produces exactly N output copies of the escape value. For example, 0x00 0x04 gives four 0x00 bytes.
- R3: A count of 1 after an escape produces exactly one output byte.
- R4: An escape followed by a count of 0 produces no output and sets the zero-count error output to 1.
- R5: While a run is being written out, in_ready_o stays 0.
- R6: An end-of-image pulse that arrives while the count byte is still outstanding sets the truncation error output to 1 and returns the decoder to idle. The next byte is then treated as a fresh literal or escape.
- R7: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o does not change.
- R8: out_count_o rises by one for each cycle in which out_valid_o and out_ready_i are both 1, and does not change otherwise.
- R9: A start pulse clears out_valid_o, both error outputs and out_count_o, and returns the decoder to idle.
- R10: Both error outputs stay at 1 until the next start pulse or reset, whatever the input does.
- R11: After reset, out_valid_o is 0, in_ready_o is 1, both error outputs are 0 and out_count_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start-of-image pulse; clears state, flags and counter |
| eoi_i | input | 1 | End-of-image pulse |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | DATA_W | Compressed input byte |
| in_ready_o | output | 1 | Decoder can accept the input byte |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | DATA_W | Expanded output byte |
| out_ready_i | input | 1 | Sink accepts the output byte |
| out_count_o | output | CNT_W | Bytes delivered since the last start or reset |
| err_zero_cnt_o | output | 1 | Sticky flag: escape with a count of zero |
| err_trunc_o | output | 1 | Sticky flag: image ended while a count was pending |

## Verification
The hardest condition to reach is a run that is in progress while the sink is stalled and the next compressed byte is already waiting. Only in that condition can the input be wrongly taken in the middle of a run. The stimulus sends an escape with a long count, holds the output ready low for several cycles, and offers a literal throughout. It then checks that the input stays blocked and that the held byte does not change. A truncated image is produced by sending an escape as the last byte and then pulsing end-of-image, followed by a literal that must pass unchanged. Random streams with random sink back-pressure cover runs of every short length, literals that sit next to escapes, and handshakes on both sides in the same cycle.

// File: rtl/rle_pkg.sv
// Shared definitions for the escape-byte run-length expander.
// Assumes a single clock domain; the state encoding is not visible outside the block.
package rle_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,  // literal pass-through, waiting for any byte
        ST_WAIT_CNT = 2'd1,  // escape seen, count byte outstanding
        ST_EMIT     = 2'd2   // run down-counter active
    } dec_state_t;
endpackage

// File: rtl/rle_ctrl.sv
// Decoder control: classifies input bytes, holds the escape value and the
// remaining run length, and pushes one byte per cycle into the output stage.
// Assumes slot_free is 1 whenever the output stage can take a byte this cycle.
module rle_ctrl
    import rle_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              eoi,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              slot_free,
    output logic              load,
    output logic [DATA_W-1:0] load_data,
    output logic              run_active,
    output logic              wait_cnt,
    output logic              zero_pulse,
    output logic              trunc_pulse
);
    localparam logic [DATA_W-1:0] ALL_ZERO = '0;
    localparam logic [DATA_W-1:0] ALL_ONE  = '1;
    localparam logic [DATA_W-1:0] LAST_ONE = DATA_W'(1);

    dec_state_t        st_q, st_d;
    logic [DATA_W-1:0] esc_q;
    logic [DATA_W-1:0] left_q;
    logic              is_esc;
    logic              acc;

    // Detect the two escape values on the incoming byte.
    always_comb is_esc = (in_data == ALL_ZERO) || (in_data == ALL_ONE);

    // Input readiness depends on the state and on a free output slot.
    always_comb begin
        case (st_q)
            ST_IDLE:     in_ready = slot_free;
            ST_WAIT_CNT: in_ready = !eoi;
            default:     in_ready = 1'b0;
        endcase
        if (clr) in_ready = 1'b0;
    end

    always_comb acc = in_valid && in_ready;

    // Next-state and output-load decisions.
    always_comb begin
        st_d        = st_q;
        load        = 1'b0;
        load_data   = in_data;
        zero_pulse  = 1'b0;
        trunc_pulse = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (acc) begin
                    if (is_esc) st_d = ST_WAIT_CNT;
                    else        load = 1'b1;
                end
            end
            ST_WAIT_CNT: begin
                if (eoi) begin
                    trunc_pulse = 1'b1;
                    st_d        = ST_IDLE;
                end else if (acc) begin
                    if (in_data == ALL_ZERO) begin
                        zero_pulse = 1'b1;
                        st_d       = ST_IDLE;
                    end else begin
                        st_d = ST_EMIT;
                    end
                end
            end
            ST_EMIT: begin
                if (slot_free) begin
                    load      = 1'b1;
                    load_data = esc_q;
                    if (left_q == LAST_ONE) st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (clr) begin
            st_d        = ST_IDLE;
            load        = 1'b0;
            zero_pulse  = 1'b0;
            trunc_pulse = 1'b0;
        end
    end

    // State, escape value and remaining run length registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            esc_q  <= '0;
            left_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && acc && is_esc)
                esc_q <= in_data;
            if (st_q == ST_WAIT_CNT && acc && in_data != ALL_ZERO)
                left_q <= in_data;
            else if (st_q == ST_EMIT && slot_free)
                left_q <= left_q - LAST_ONE;
        end
    end

    always_comb run_active = (st_q == ST_EMIT);
    always_comb wait_cnt   = (st_q == ST_WAIT_CNT);
endmodule

// File: rtl/rle_out_stage.sv
// Single-entry output register with valid/ready handshake.
// Assumes load is raised only when slot_free is 1.
module rle_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              slot_free
);
    // The slot is free when empty or when its byte leaves this cycle.
    always_comb slot_free = !out_valid || out_ready;

    // Hold or replace the output byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/rle_err_flags.sv
// Sticky error flags, cleared only by reset or the start pulse.
module rle_err_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic zero_pulse,
    input  logic trunc_pulse,
    output logic err_zero,
    output logic err_trunc
);
    // Set on a pulse, hold until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err_zero  <= 1'b0;
            err_trunc <= 1'b0;
        end else begin
            if (zero_pulse)  err_zero  <= 1'b1;
            if (trunc_pulse) err_trunc <= 1'b1;
        end
    end
endmodule

// File: rtl/rle_xfer_counter.sv
// Counts completed output handshakes; wraps at its width.
module rle_xfer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             xfer,
    output logic [CNT_W-1:0] count
);
    // Increment once per delivered byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (xfer)     count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/rle_byte_expander.sv
// Top level of the escape-byte run-length expander.
// Assumes start_i and eoi_i are single-cycle pulses in the clk domain.
module rle_byte_expander #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              eoi_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    input  logic              out_ready_i,
    output logic [CNT_W-1:0]  out_count_o,
    output logic              err_zero_cnt_o,
    output logic              err_trunc_o
);
    logic              slot_free;
    logic              load;
    logic [DATA_W-1:0] load_data;
    logic              run_active;
    logic              wait_cnt;
    logic              zero_pulse;
    logic              trunc_pulse;
    logic              xfer;

    rle_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start_i),
        .eoi        (eoi_i),
        .in_valid   (in_valid_i),
        .in_data    (in_data_i),
        .in_ready   (in_ready_o),
        .slot_free  (slot_free),
        .load       (load),
        .load_data  (load_data),
        .run_active (run_active),
        .wait_cnt   (wait_cnt),
        .zero_pulse (zero_pulse),
        .trunc_pulse(trunc_pulse)
    );

    rle_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_i),
        .load     (load),
        .load_data(load_data),
        .out_ready(out_ready_i),
        .out_valid(out_valid_o),
        .out_data (out_data_o),
        .slot_free(slot_free)
    );

    rle_err_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start_i),
        .zero_pulse (zero_pulse),
        .trunc_pulse(trunc_pulse),
        .err_zero   (err_zero_cnt_o),
        .err_trunc  (err_trunc_o)
    );

    // A byte leaves the block on a completed output handshake.
    always_comb xfer = out_valid_o && out_ready_i;

    rle_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start_i),
        .xfer (xfer),
        .count(out_count_o)
    );
endmodule

// File: rtl/rle_expander_checker.sv
// Protocol and behaviour properties for rle_byte_expander, bound to the top.
module rle_expander_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              eoi_i,
    input logic              in_valid_i,
    input logic [DATA_W-1:0] in_data_i,
    input logic              in_ready_o,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] out_data_o,
    input logic              out_ready_i,
    input logic [CNT_W-1:0]  out_count_o,
    input logic              err_zero_cnt_o,
    input logic              err_trunc_o,
    input logic              run_active,
    input logic              wait_cnt
);
    localparam logic [DATA_W-1:0] ALL_ZERO = '0;
    localparam logic [DATA_W-1:0] ALL_ONE  = '1;

    assert_literal_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && !wait_cnt && !start_i &&
         in_data_i != ALL_ZERO && in_data_i != ALL_ONE)
        |=> (out_valid_o && out_data_o == $past(in_data_i)));

    assert_zero_count_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_cnt && in_valid_i && in_ready_o && in_data_i == ALL_ZERO && !start_i)
        |=> (err_zero_cnt_o && !run_active));

    assert_no_input_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_active |-> !in_ready_o);

    assert_trunc_on_eoi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_cnt && eoi_i && !start_i) |=> (err_trunc_o && !wait_cnt && !run_active));

    assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && !start_i) |=> (out_valid_o && $stable(out_data_o)));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (out_count_o == $past(out_count_o) +
                      CNT_W'($past(out_valid_o && out_ready_i))));

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!out_valid_o && !err_zero_cnt_o && !err_trunc_o &&
                     out_count_o == '0 && !run_active && !wait_cnt));

    assert_zero_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_zero_cnt_o && !start_i) |=> err_zero_cnt_o);

    assert_trunc_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_trunc_o && !start_i) |=> err_trunc_o);
endmodule

bind rle_byte_expander rle_expander_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .eoi_i         (eoi_i),
    .in_valid_i    (in_valid_i),
    .in_data_i     (in_data_i),
    .in_ready_o    (in_ready_o),
    .out_valid_o   (out_valid_o),
    .out_data_o    (out_data_o),
    .out_ready_i   (out_ready_i),
    .out_count_o   (out_count_o),
    .err_zero_cnt_o(err_zero_cnt_o),
    .err_trunc_o   (err_trunc_o),
    .run_active    (run_active),
    .wait_cnt      (wait_cnt)
);

// File: tb/rle_byte_expander_tb.sv
// Self-checking bench: directed corner cases plus seeded random streams.
module rle_byte_expander_tb;
    typedef logic [7:0] bq_t[$];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        eoi_i = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic [31:0] out_count;
    logic        err_zero;
    logic        err_trunc;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   exp_total = 0;
    bit   zerr_exp = 1'b0;
    bq_t  enc;

    always #5 clk = ~clk;

    rle_byte_expander #(.DATA_W(8), .CNT_W(32)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .eoi_i         (eoi_i),
        .in_valid_i    (in_valid),
        .in_data_i     (in_data),
        .in_ready_o    (in_ready),
        .out_valid_o   (out_valid),
        .out_data_o    (out_data),
        .out_ready_i   (out_ready),
        .out_count_o   (out_count),
        .err_zero_cnt_o(err_zero),
        .err_trunc_o   (err_trunc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference expansion computed from the requirements.
    function automatic void decode(input bq_t e, output bq_t d, output bit zerr);
        d = {};
        zerr = 1'b0;
        for (int i = 0; i < e.size(); i++) begin
            if (e[i] == 8'h00 || e[i] == 8'hFF) begin
                if (i + 1 < e.size()) begin
                    if (e[i+1] == 8'h00) zerr = 1'b1;
                    else for (int k = 0; k < int'(e[i+1]); k++) d.push_back(e[i]);
                end
                i++;
            end else begin
                d.push_back(e[i]);
            end
        end
    endfunction

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        exp_total = 0;
        zerr_exp  = 1'b0;
    endtask

    // Drive enc through the block and compare every output byte.
    task automatic run_stream(input bit do_start, input int rdy_pct, input string req);
        bq_t d;
        bit zerr;
        int idx = 0, oidx = 0, bad = 0, guard = 0, extra = 0;
        longint act0 = 0, exp0 = 0;
        decode(enc, d, zerr);
        if (do_start) pulse_start();
        if (zerr) zerr_exp = 1'b1;
        while ((idx < enc.size() || oidx < d.size()) && guard < 40000) begin
            @(negedge clk);
            guard++;
            in_valid  = (idx < enc.size()) && (($urandom % 100) < 80);
            in_data   = (idx < enc.size()) ? enc[idx] : 8'h00;
            out_ready = (($urandom % 100) < rdy_pct);
            #2;
            if (in_valid && in_ready) idx++;
            if (out_valid && out_ready) begin
                if (oidx >= d.size() || out_data !== d[oidx]) begin
                    if (bad == 0) begin
                        act0 = longint'(out_data);
                        exp0 = (oidx < d.size()) ? longint'(d[oidx]) : -1;
                    end
                    bad++;
                end
                oidx++;
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        for (int c = 0; c < 4; c++) begin
            #2;
            if (out_valid) extra++;
            @(negedge clk);
        end
        exp_total += d.size();
        chk(bad == 0 && guard < 40000, req, "output byte", act0, exp0);
        chk(extra == 0 && oidx == d.size(), req, "output length", oidx + extra, d.size());
        chk(out_count == 32'(exp_total), "R8", "out_count", out_count, exp_total);
        chk(err_zero == zerr_exp, "R4", "zero-count flag", err_zero, zerr_exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240617));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        // R11: reset state
        chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);
        chk(err_zero == 1'b0 && err_trunc == 1'b0, "R11", "error flags after reset",
            {err_zero, err_trunc}, 0);
        chk(out_count == 32'd0, "R11", "out_count after reset", out_count, 0);

        // R1: literals only, including neighbours of the escape values
        enc = '{8'h12, 8'h34, 8'hFE, 8'h01, 8'h80, 8'h7F};
        run_stream(1'b1, 100, "R1");
        // R2: four zeros from one pair, then a 255-long ones run
        enc = '{8'h00, 8'h04};
        run_stream(1'b1, 60, "R2");
        enc = '{8'hFF, 8'hFF, 8'h5A};
        run_stream(1'b1, 90, "R2");
        // R3: counts of one
        enc = '{8'hFF, 8'h01, 8'h00, 8'h01, 8'h22};
        run_stream(1'b1, 50, "R3");

        // R4: zero count emits nothing and flags; R10: flag stays through more input
        enc = '{8'h55, 8'h00, 8'h00, 8'h66};
        run_stream(1'b1, 70, "R4");
        enc = '{8'h00, 8'h03, 8'h44};
        run_stream(1'b0, 70, "R10");
        chk(err_zero == 1'b1, "R10", "zero flag sticky", err_zero, 1);
        // R9: start clears flag and counter
        pulse_start();
        #2;
        chk(err_zero == 1'b0 && out_count == 32'd0 && out_valid == 1'b0, "R9",
            "state after start", {err_zero, out_valid}, 0);

        // R6: image ends right after an escape
        enc = '{8'hAA, 8'hFF};
        run_stream(1'b1, 100, "R6");
        @(negedge clk) eoi_i = 1'b1;
        @(negedge clk) eoi_i = 1'b0;
        #2;
        chk(err_trunc == 1'b1, "R6", "truncation flag", err_trunc, 1);
        enc = '{8'h33};
        run_stream(1'b0, 100, "R6");
        chk(err_trunc == 1'b1, "R10", "truncation flag sticky", err_trunc, 1);
        pulse_start();
        #2;
        chk(err_trunc == 1'b0, "R9", "truncation flag cleared", err_trunc, 0);

        // R5 and R7: long run with stalled sink and a waiting literal
        begin
            int bad_rdy = 0, bad_hold = 0, zeros = 0, got77 = 0, guard = 0;
            bit sent = 1'b0;
            out_ready = 1'b0;
            @(negedge clk) begin in_valid = 1'b1; in_data = 8'h00; end
            @(negedge clk) in_data = 8'd200;
            @(negedge clk) in_data = 8'h77;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                #2;
                if (in_ready) bad_rdy++;
                if (!out_valid || out_data != 8'h00) bad_hold++;
            end
            chk(bad_rdy == 0, "R5", "in_ready during run", bad_rdy, 0);
            chk(bad_hold == 0, "R7", "held output", bad_hold, 0);
            while (got77 == 0 && guard < 2000) begin
                @(negedge clk);
                guard++;
                in_valid  = !sent;
                out_ready = (($urandom % 100) < 75);
                #2;
                if (in_valid && in_ready) sent = 1'b1;
                if (out_valid && out_ready) begin
                    if (out_data == 8'h77) got77 = 1;
                    else if (out_data == 8'h00) zeros++;
                end
            end
            @(negedge clk) begin in_valid = 1'b0; out_ready = 1'b1; end
            chk(zeros == 200 && got77 == 1, "R2", "run of 200 then literal", zeros, 200);
            chk(out_count == 32'd201, "R8", "out_count after run", out_count, 201);
            exp_total = 201;
        end

        // Random streams under varying back-pressure
        for (int s = 0; s < 20; s++) begin
            int n;
            enc = {};
            n = 10 + int'($urandom % 21);
            for (int j = 0; j < n; j++) begin
                if (($urandom % 100) < 60) begin
                    enc.push_back(8'(1 + ($urandom % 254)));
                end else begin
                    enc.push_back((($urandom % 2) == 0) ? 8'h00 : 8'hFF);
                    enc.push_back(8'(1 + ($urandom % 40)));
                end
            end
            run_stream(1'b1, 30 + int'($urandom % 71), "R2");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule